// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Transceiver

This block moves one to eight bits over a single-wire open-drain bus, one time slot per bit, least-significant bit first. For every slot it pulls the line low for a length that encodes the bit being sent, releases it, and then times how long the line actually stayed low. The measured low width is decoded into the received bit. To read, software sends all ones: a device that answers '0' stretches the low time, and the block sees the longer pulse. Line reset and device-presence handling are left to a separate block.

All timing is counted in microsecond ticks supplied by the `us_tick_i` strobe, so the block runs from any system clock. A speed select chooses between the normal and the fast (overdrive) timing sets for the whole operation. When the last bit of an operation has been decoded without fault, the block can switch on a strong pull-up output to power the bus. That output stays on until the next operation is accepted.

Top module: `owb_slot_xcvr`

## Requirements
- R1: In each slot the block asserts `pull_low_o` for 8 us when sending a 1 and 90 us when sending a 0 at normal speed, and for 1 us and 11 us in overdrive; bit 0 of `tx_byte_i` goes out in the first slot.
- R2: Consecutive slots of one operation start 121 us apart at normal speed and 17 us apart in overdrive.
- R3: A measured low width (falling edge of the slot to the first rising edge of `bus_i`, in whole ticks) below 15 us normal or 2 us overdrive decodes as 1, otherwise as 0.
- R4: A low width below 1 us, or above 120 us normal / 16 us overdrive, ends the operation at once with `done_o` and `err_o` high.
- R5: If no rising edge is seen before the slot time runs out, the operation ends with `done_o` and `err_o` high.
- R6: On success `rx_byte_o` holds the decoded bits right-aligned, first received bit at bit 0; a `bit_cnt_i` of 0 or above 8 is handled as 8.
- R7: After a successful operation requested with `spu_req_i` high, `spu_en_o` rises with `done_o` and falls on the next accepted start; it never turns on after an error.
- R8: `start_i` is accepted only while idle; a start during an operation changes nothing, and `done_o` is high for exactly one cycle per operation.
- R9: `err_o` holds its value until the next accepted start, and `rx_byte_o` keeps its previous value when an operation fails.
- R10: After reset all outputs are low and `rx_byte_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only while idle) |
| tx_byte_i | input | 8 | Bits to send, LSB first; all ones to read |
| bit_cnt_i | input | 4 | Number of slots, 1 to 8 |
| spu_req_i | input | 1 | Turn on strong pull-up after a good finish |
| od_i | input | 1 | Select fast timing for this operation |
| us_tick_i | input | 1 | One-cycle strobe every microsecond |
| bus_i | input | 1 | Synchronised bus level |
| pull_low_o | output | 1 | Drive the bus low |
| spu_en_o | output | 1 | Strong pull-up enable |
| rx_byte_o | output | 8 | Received bits, right-aligned |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Last operation failed |

## Verification
The slot timer running out and a late rising edge on the line can land in the same cycle: a device model that releases the bus exactly 121 us (normal) or 17 us (overdrive) into a slot makes the edge visible in the very cycle the slot expires. The bench expects a single `done_o` with `err_o` set, because the width check and the timeout both call it a fault, and it also checks that no further slot starts. The edges on each side of that window (120 us and 16 us, decoded as 0) are run as well, so a wrong comparison bound shows up as a wrong bit or a missing error.

// File: rtl/owb_slot_pkg.sv
// Shared types for the bit-slot transceiver.
// Assumes every time value fits in TIME_W bits of microseconds.
package owb_slot_pkg;

    localparam int TIME_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } owb_state_e;

    typedef struct packed {
        logic [TIME_W-1:0] lo_one;    // low time sent for a 1
        logic [TIME_W-1:0] lo_zero;   // low time sent for a 0
        logic [TIME_W-1:0] one_min;   // shortest legal low width
        logic [TIME_W-1:0] one_max;   // widths below this decode as 1
        logic [TIME_W-1:0] zero_max;  // longest legal low width
        logic [TIME_W-1:0] slot_len;  // slot period in ticks
    } owb_timing_t;

endpackage

// File: rtl/owb_slot_timing.sv
// Selects the timing set for the running operation and the low time for
// the bit now at the head of the shift register.
// Assumes all parameter values are below 2**TIME_W.
module owb_slot_timing
    import owb_slot_pkg::*;
#(
    parameter int N_ONE_LO   = 8,
    parameter int N_ZERO_LO  = 90,
    parameter int N_ONE_MAX  = 15,
    parameter int N_ZERO_MAX = 120,
    parameter int O_ONE_LO   = 1,
    parameter int O_ZERO_LO  = 11,
    parameter int O_ONE_MAX  = 2,
    parameter int O_ZERO_MAX = 16,
    parameter int ONE_MIN    = 1,
    parameter int REC_MIN    = 1
) (
    input  logic              od_i,
    input  logic              tx_bit_i,
    output owb_timing_t       tim_o,
    output logic [TIME_W-1:0] lo_len_o
);

    localparam int N_SLOT = N_ZERO_MAX + REC_MIN;
    localparam int O_SLOT = O_ZERO_MAX + REC_MIN;

    localparam owb_timing_t NRM_T = '{
        lo_one:   TIME_W'(N_ONE_LO),
        lo_zero:  TIME_W'(N_ZERO_LO),
        one_min:  TIME_W'(ONE_MIN),
        one_max:  TIME_W'(N_ONE_MAX),
        zero_max: TIME_W'(N_ZERO_MAX),
        slot_len: TIME_W'(N_SLOT)
    };

    localparam owb_timing_t FAST_T = '{
        lo_one:   TIME_W'(O_ONE_LO),
        lo_zero:  TIME_W'(O_ZERO_LO),
        one_min:  TIME_W'(ONE_MIN),
        one_max:  TIME_W'(O_ONE_MAX),
        zero_max: TIME_W'(O_ZERO_MAX),
        slot_len: TIME_W'(O_SLOT)
    };

    // Pick the speed set, then the low time of the current bit.
    always_comb begin
        tim_o    = od_i ? FAST_T : NRM_T;
        lo_len_o = tx_bit_i ? tim_o.lo_one : tim_o.lo_zero;
    end

endmodule

// File: rtl/owb_slot_timer.sv
// Microsecond slot timer and rising-edge detector on the bus input.
// Assumes bus_i is already synchronised to clk.
module owb_slot_timer
    import owb_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [TIME_W-1:0] limit_i,
    input  logic              bus_i,
    output logic [TIME_W-1:0] t_o,
    output logic              rise_o
);

    logic bus_q;

    // Count ticks since slot start, stopping at the slot period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_o <= '0;
        end else if (clr_i) begin
            t_o <= '0;
        end else if (run_i && tick_i && (t_o < limit_i)) begin
            t_o <= t_o + 1'b1;
        end
    end

    // Keep the previous bus level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= 1'b1;
        end else begin
            bus_q <= bus_i;
        end
    end

    assign rise_o = bus_i & ~bus_q;

endmodule

// File: rtl/owb_slot_shifter.sv
// Transmit/receive shift register and right-aligned result register.
// Assumes n_bits_i is already in 1..DATA_W when cap_i is high.
module owb_slot_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    input  logic              shift_bit_i,
    input  logic              cap_i,
    input  logic [CNT_W-1:0]  n_bits_i,
    output logic              head_o,
    output logic [DATA_W-1:0] rx_o
);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_next;
    logic [DATA_W-1:0] cand [1:DATA_W];
    logic [DATA_W-1:0] rx_sel;

    assign sr_next = {shift_bit_i, sr_q[DATA_W-1:1]};
    assign head_o  = sr_q[0];

    // One aligned candidate per possible bit count.
    for (genvar k = 1; k <= DATA_W; k++) begin : g_align
        assign cand[k] = sr_next >> (DATA_W - k);
    end

    // Choose the candidate matching the operation length.
    always_comb begin
        rx_sel = sr_next;
        for (int k = 1; k <= DATA_W; k++) begin
            if (n_bits_i == CNT_W'(k)) begin
                rx_sel = cand[k];
            end
        end
    end

    // Load data at start, insert each decoded bit at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_data_i;
        end else if (shift_i) begin
            sr_q <= sr_next;
        end
    end

    // Publish the result only on a good finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_o <= '0;
        end else if (cap_i) begin
            rx_o <= rx_sel;
        end
    end

endmodule

// File: rtl/owb_slot_ctrl.sv
// Operation sequencer: accepts a start, runs one slot per bit, decodes
// each measured low width and ends with a done pulse, error or pull-up.
// Assumes the timer holds the tick count since the current slot began.
module owb_slot_ctrl
    import owb_slot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              spu_req_i,
    input  logic              od_i,
    input  logic              rise_i,
    input  logic [TIME_W-1:0] t_i,
    input  owb_timing_t       tim_i,
    input  logic [TIME_W-1:0] lo_len_i,
    output logic              load_o,
    output logic              shift_o,
    output logic              shift_bit_o,
    output logic              cap_o,
    output logic              t_clr_o,
    output logic              run_o,
    output logic              od_q_o,
    output logic [CNT_W-1:0]  n_bits_o,
    output logic              pull_low_o,
    output logic              spu_en_o,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    owb_state_e       state_q;
    logic [CNT_W-1:0] idx_q;
    logic             spu_req_q;
    logic             seen_q;

    logic [CNT_W-1:0] cnt_fix;
    logic             accept;
    logic             decode_ev;
    logic             expire_ev;
    logic             bad_width;
    logic             last_bit;
    logic             finish_ok;
    logic             finish_err;
    logic             next_slot;

    // Event decoding for the current cycle.
    always_comb begin
        cnt_fix     = ((cnt_i == '0) || (cnt_i > FULL_CNT)) ? FULL_CNT : cnt_i;
        accept      = start_i && (state_q == ST_IDLE);
        decode_ev   = (state_q == ST_SLOT) && rise_i && !seen_q;
        expire_ev   = (state_q == ST_SLOT) && !decode_ev && (t_i >= tim_i.slot_len);
        bad_width   = (t_i < tim_i.one_min) || (t_i > tim_i.zero_max);
        last_bit    = (idx_q == (n_bits_o - ONE_CNT));
        shift_bit_o = (t_i < tim_i.one_max);
        shift_o     = decode_ev && !bad_width;
        finish_ok   = shift_o && last_bit;
        finish_err  = (decode_ev && bad_width) || (expire_ev && !seen_q);
        next_slot   = expire_ev && seen_q;
        cap_o       = finish_ok;
        load_o      = accept;
        t_clr_o     = accept || next_slot;
        run_o       = (state_q == ST_SLOT);
        pull_low_o  = (state_q == ST_SLOT) && !seen_q && (t_i < lo_len_i);
    end

    // Operation state, slot index and per-operation settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            n_bits_o  <= FULL_CNT;
            spu_req_q <= 1'b0;
            od_q_o    <= 1'b0;
            seen_q    <= 1'b0;
        end else if (accept) begin
            state_q   <= ST_SLOT;
            idx_q     <= '0;
            n_bits_o  <= cnt_fix;
            spu_req_q <= spu_req_i;
            od_q_o    <= od_i;
            seen_q    <= 1'b0;
        end else if (finish_ok || finish_err) begin
            state_q   <= ST_IDLE;
        end else if (shift_o) begin
            seen_q    <= 1'b1;
        end else if (next_slot) begin
            idx_q     <= idx_q + ONE_CNT;
            seen_q    <= 1'b0;
        end
    end

    // Result flags: done pulse, sticky error, strong pull-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            err_o    <= 1'b0;
            spu_en_o <= 1'b0;
        end else begin
            done_o <= finish_ok || finish_err;
            if (accept) begin
                err_o    <= 1'b0;
                spu_en_o <= 1'b0;
            end else if (finish_err) begin
                err_o    <= 1'b1;
            end else if (finish_ok) begin
                spu_en_o <= spu_req_q;
            end
        end
    end

endmodule

// File: rtl/owb_slot_xcvr.sv
// Top of the bit-slot transceiver: sends up to DATA_W bits LSB first and
// decodes each slot from the measured low width on the bus.
// Assumes us_tick_i is a one-cycle strobe per microsecond and bus_i is
// synchronised; timing parameters must stay below 2**TIME_W.
module owb_slot_xcvr
    import owb_slot_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int N_ONE_LO   = 8,
    parameter int N_ZERO_LO  = 90,
    parameter int N_ONE_MAX  = 15,
    parameter int N_ZERO_MAX = 120,
    parameter int O_ONE_LO   = 1,
    parameter int O_ZERO_LO  = 11,
    parameter int O_ONE_MAX  = 2,
    parameter int O_ZERO_MAX = 16,
    parameter int ONE_MIN    = 1,
    parameter int REC_MIN    = 1,
    localparam int CNT_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    input  logic              spu_req_i,
    input  logic              od_i,
    input  logic              us_tick_i,
    input  logic              bus_i,
    output logic              pull_low_o,
    output logic              spu_en_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              done_o,
    output logic              err_o
);

    owb_timing_t       tim;
    logic [TIME_W-1:0] lo_len;
    logic [TIME_W-1:0] t_cur;
    logic              rise;
    logic              head_bit;
    logic              od_q;
    logic              load;
    logic              shift;
    logic              shift_bit;
    logic              cap;
    logic              t_clr;
    logic              run;
    logic [CNT_W-1:0]  n_bits;

    owb_slot_timing #(
        .N_ONE_LO  (N_ONE_LO),
        .N_ZERO_LO (N_ZERO_LO),
        .N_ONE_MAX (N_ONE_MAX),
        .N_ZERO_MAX(N_ZERO_MAX),
        .O_ONE_LO  (O_ONE_LO),
        .O_ZERO_LO (O_ZERO_LO),
        .O_ONE_MAX (O_ONE_MAX),
        .O_ZERO_MAX(O_ZERO_MAX),
        .ONE_MIN   (ONE_MIN),
        .REC_MIN   (REC_MIN)
    ) u_timing (
        .od_i    (od_q),
        .tx_bit_i(head_bit),
        .tim_o   (tim),
        .lo_len_o(lo_len)
    );

    owb_slot_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (t_clr),
        .run_i  (run),
        .tick_i (us_tick_i),
        .limit_i(tim.slot_len),
        .bus_i  (bus_i),
        .t_o    (t_cur),
        .rise_o (rise)
    );

    owb_slot_shifter #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_data_i(tx_byte_i),
        .shift_i    (shift),
        .shift_bit_i(shift_bit),
        .cap_i      (cap),
        .n_bits_i   (n_bits),
        .head_o     (head_bit),
        .rx_o       (rx_byte_o)
    );

    owb_slot_ctrl #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cnt_i      (bit_cnt_i),
        .spu_req_i  (spu_req_i),
        .od_i       (od_i),
        .rise_i     (rise),
        .t_i        (t_cur),
        .tim_i      (tim),
        .lo_len_i   (lo_len),
        .load_o     (load),
        .shift_o    (shift),
        .shift_bit_o(shift_bit),
        .cap_o      (cap),
        .t_clr_o    (t_clr),
        .run_o      (run),
        .od_q_o     (od_q),
        .n_bits_o   (n_bits),
        .pull_low_o (pull_low_o),
        .spu_en_o   (spu_en_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/owb_slot_xcvr_chk.sv
// Port-level property checker for the bit-slot transceiver, bound below.
module owb_slot_xcvr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              pull_low_o,
    input logic              spu_en_o,
    input logic [DATA_W-1:0] rx_byte_o,
    input logic              done_o,
    input logic              err_o
);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pull_low_o);

    assert_spu_no_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spu_en_o |-> !pull_low_o);

    assert_err_no_spu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !spu_en_o);

    assert_start_drops_spu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spu_en_o && start_i) |=> !spu_en_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rx_byte_o));

    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

endmodule

bind owb_slot_xcvr owb_slot_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pull_low_o(pull_low_o),
    .spu_en_o  (spu_en_o),
    .rx_byte_o (rx_byte_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/owb_slot_xcvr_bench.sv
// Bench: device model on the bus, directed corners plus seeded random ops.
module owb_slot_xcvr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic [3:0] bit_cnt_i = 4'd8;
    logic       spu_req_i = 1'b0;
    logic       od_i = 1'b0;
    logic       us_tick_i;
    logic       bus_i;
    logic       pull_low_o;
    logic       spu_en_o;
    logic [7:0] rx_byte_o;
    logic       done_o;
    logic       err_o;

    int n_checks = 0;
    int n_fail   = 0;

    // tick and bus model state
    logic tick_ph = 1'b0;
    logic mute = 1'b0;
    logic force_high = 1'b0;
    logic pull_prev = 1'b0;
    int   cnt = 400;
    int   cur_hold = 0;
    int   slot_n = 0;
    int   op_base = 0;
    int   hold_q [8];

    // slot monitors
    int pw_run = 0, pw_last = 0;
    int sp_cyc = 0, sp_last = 0;

    always #2 clk = ~clk;

    assign us_tick_i = tick_ph & ~mute;
    assign bus_i = force_high | ~(pull_low_o | (cnt < cur_hold));

    owb_slot_xcvr u_owb_slot_xcvr (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_byte_i(tx_byte_i),
        .bit_cnt_i(bit_cnt_i), .spu_req_i(spu_req_i), .od_i(od_i),
        .us_tick_i(us_tick_i), .bus_i(bus_i), .pull_low_o(pull_low_o),
        .spu_en_o(spu_en_o), .rx_byte_o(rx_byte_o), .done_o(done_o), .err_o(err_o)
    );

    always @(posedge clk) tick_ph <= ~tick_ph;

    // Device model: mirrors the slot timer and holds the line for cur_hold us.
    always @(posedge clk) begin
        pull_prev <= pull_low_o;
        if (pull_low_o && !pull_prev) begin
            cnt      <= us_tick_i ? 1 : 0;
            cur_hold <= hold_q[(slot_n - op_base) & 7];
            slot_n   <= slot_n + 1;
        end else if (us_tick_i && cnt < 400) begin
            cnt <= cnt + 1;
        end
    end

    // Pulse width and slot spacing in cycles.
    always @(posedge clk) begin
        if (pull_low_o) pw_run <= pw_run + 1;
        else if (pw_run != 0) begin pw_last <= pw_run; pw_run <= 0; end
        if (pull_low_o && !pull_prev) begin sp_last <= sp_cyc; sp_cyc <= 1; end
        else sp_cyc <= sp_cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result of one operation from the requirements.
    function automatic void model(input logic [7:0] tx, input int n, input bit od,
                                  output bit err, output logic [7:0] rx);
        int nn, lo, w, zmax, omax;
        nn = (n == 0 || n > 8) ? 8 : n;
        zmax = od ? 16 : 120;
        omax = od ? 2 : 15;
        err = 0;
        rx = 8'h00;
        for (int i = 0; i < nn; i++) begin
            lo = od ? (tx[i] ? 1 : 11) : (tx[i] ? 8 : 90);
            w = (hold_q[i] > lo) ? hold_q[i] : lo;
            if (w < 1 || w > zmax) begin err = 1; break; end
            if (w < omax) rx[i] = 1'b1;
        end
    endfunction

    task automatic set_holds(input int h);
        for (int i = 0; i < 8; i++) hold_q[i] = h;
    endtask

    task automatic wait_bus_high();
        @(negedge clk);
        while (!bus_i) @(negedge clk);
    endtask

    // Run one operation and check done, error, data and pull-up.
    task automatic run_op(input logic [7:0] tx, input int n, input bit spu, input bit od,
                          input string tag);
        bit eerr; logic [7:0] erx; logic [7:0] prev_rx; bit had_spu; int lim;
        model(tx, n, od, eerr, erx);
        wait_bus_high();
        prev_rx = rx_byte_o;
        had_spu = spu_en_o;
        op_base = slot_n;
        tx_byte_i = tx; bit_cnt_i = 4'(n); spu_req_i = spu; od_i = od;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (had_spu) chk(spu_en_o == 1'b0, "R7 pull-up off at start", spu_en_o, 0);
        lim = 0;
        while (!done_o && lim < 6000) begin @(negedge clk); lim++; end
        chk(done_o == 1'b1, {tag, " R8 done seen"}, done_o, 1);
        chk(err_o == eerr, {tag, " R4/R5 error flag"}, err_o, eerr);
        if (eerr) chk(rx_byte_o == prev_rx, {tag, " R9 rx kept on error"}, rx_byte_o, prev_rx);
        else      chk(rx_byte_o == erx, {tag, " R3/R6 received byte"}, rx_byte_o, erx);
        chk(spu_en_o == (spu && !eerr), {tag, " R7 pull-up state"}, spu_en_o, spu && !eerr);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R8 done one cycle"}, done_o, 0);
        chk(err_o == eerr, {tag, " R9 error held"}, err_o, eerr);
    endtask

    initial begin
        set_holds(0);
        repeat (20000 * 9) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] tx;
        bit od;
        int n, r;
        void'($urandom(32'd2718));
        set_holds(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(pull_low_o == 0 && spu_en_o == 0 && done_o == 0 && err_o == 0,
            "R10 outputs low after reset", {pull_low_o, spu_en_o, done_o, err_o}, 0);
        chk(rx_byte_o == 0, "R10 rx zero after reset", rx_byte_o, 0);

        // R1 pulse widths, single-bit writes
        run_op(8'h01, 1, 0, 0, "R1 n1");
        chk(pw_last >= 15 && pw_last <= 16, "R1 normal one width", pw_last, 16);
        run_op(8'h00, 1, 0, 0, "R1 n0");
        chk(pw_last >= 179 && pw_last <= 180, "R1 normal zero width", pw_last, 180);
        run_op(8'h01, 1, 0, 1, "R1 o1");
        chk(pw_last >= 1 && pw_last <= 2, "R1 fast one width", pw_last, 2);
        run_op(8'h00, 1, 0, 1, "R1 o0");
        chk(pw_last >= 21 && pw_last <= 22, "R1 fast zero width", pw_last, 22);

        // R2 slot spacing
        run_op(8'h02, 2, 0, 0, "R2 normal");
        chk(sp_last >= 242 && sp_last <= 243, "R2 normal spacing", sp_last, 242);
        run_op(8'h01, 2, 0, 1, "R2 fast");
        chk(sp_last >= 34 && sp_last <= 35, "R2 fast spacing", sp_last, 34);

        // R1/R6 full write, LSB first, count 0 handled as 8
        run_op(8'hA5, 8, 0, 0, "R1 write A5");
        run_op(8'h3C, 0, 0, 1, "R6 count zero");
        run_op(8'hC3, 12, 0, 1, "R6 count over");
        run_op(8'h16, 5, 0, 0, "R6 five bits");

        // R3 decode boundaries on reads
        set_holds(14); run_op(8'hFF, 2, 0, 0, "R3 hold14 is one");
        set_holds(15); run_op(8'hFF, 2, 0, 0, "R3 hold15 is zero");
        set_holds(120); run_op(8'hFF, 1, 0, 0, "R3 hold120 is zero");
        set_holds(16); run_op(8'hFF, 3, 0, 1, "R3 fast hold16");
        set_holds(2); run_op(8'hFF, 3, 0, 1, "R3 fast hold2");

        // R4/R5 edge arriving as the slot expires, and plain timeout
        set_holds(0); hold_q[1] = 121; run_op(8'hFF, 3, 1, 0, "R4 collision normal");
        set_holds(0); hold_q[0] = 17; run_op(8'hFF, 2, 1, 1, "R4 collision fast");
        set_holds(200); run_op(8'hFF, 1, 1, 0, "R5 timeout");

        // R4 width below minimum: bus pulled high right after slot start
        set_holds(0);
        wait_bus_high();
        mute = 1'b1;
        op_base = slot_n;
        tx_byte_i = 8'hFF; bit_cnt_i = 4'd8; spu_req_i = 1'b1; od_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        force_high = 1'b1; @(negedge clk); force_high = 1'b0;
        chk(done_o == 1 && err_o == 1, "R4 short width error", {done_o, err_o}, 3);
        mute = 1'b0;

        // R7 pull-up after success, dropped at next start
        run_op(8'h5A, 8, 1, 1, "R7 spu on");
        run_op(8'h05, 3, 0, 1, "R7 spu next");

        // R8 start while busy is ignored
        wait_bus_high();
        op_base = slot_n;
        tx_byte_i = 8'h9C; bit_cnt_i = 4'd8; spu_req_i = 1'b0; od_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (300) @(negedge clk);
        tx_byte_i = 8'h11; bit_cnt_i = 4'd2; od_i = 1'b1;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        n = 0;
        while (!done_o && n < 6000) begin @(negedge clk); n++; end
        chk(done_o == 1 && err_o == 0, "R8 busy start ignored done", {done_o, err_o}, 2);
        chk(rx_byte_o == 8'h9C, "R8 busy start ignored data", rx_byte_o, 8'h9C);

        // random mix
        for (int k = 0; k < 24; k++) begin
            od = $urandom % 2;
            n = 1 + ($urandom % 8);
            if ($urandom % 2) begin
                tx = $urandom;
                set_holds(0);
            end else begin
                tx = 8'hFF;
                for (int i = 0; i < 8; i++) begin
                    r = $urandom % 10;
                    if (od) hold_q[i] = (r < 4) ? $urandom % 2 : (r < 8) ? 2 + $urandom % 15 : 17 + $urandom % 10;
                    else    hold_q[i] = (r < 4) ? $urandom % 15 : (r < 9) ? 15 + $urandom % 106 : 100 + $urandom % 60;
                end
            end
            run_op(tx, n, $urandom % 2, od, "R3 random");
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule